// File: doc/BRIEF.md
# Link Configuration Fallback Selector

This block chooses which lane count and bandwidth code a serial display link should attempt to train at. It holds a fixed list of nine candidate configurations ordered from the highest aggregate throughput to the lowest. A search begins on a start pulse. The selector offers the first candidate that fits both the sink's advertised limits and the encoder's own limits. Each time the training engine reports a failed attempt, it moves on to the next candidate that fits.

Callers can optionally give a minimum payload rate. The selector first scales that rate up to account for 8b/10b line coding. It then starts the search at the cheapest candidate that still carries the scaled rate, and falls back to cheaper candidates from there. Each offer drives the bandwidth code and lane count, plus the two configuration bytes that are written to the sink. A search ends in one of three ways:

- the link trains, and `link_ok` is set;
- the configuration step fails outright, and `halted` is set;
- the list runs out, and `exhausted` is set.

Top module: `link_fallback_sel`

## Requirements
- R1: Offered configurations follow this fixed order of (bandwidth code, lanes): (20,4), (10,4), (20,2), (6,4), (10,2), (20,1), (6,2), (10,1), (6,1). Each entry's aggregate rate is code × 27000 × lanes, in kB/s.
- R2: An entry is never offered if its lane count is above the lane cap, or if its bandwidth code is above the rate cap. Such an entry is skipped silently.
- R3: The lane cap is the smaller of `sink_max_lanes` and `enc_max_lanes`. The rate cap is the smaller of `sink_max_bw` and `enc_max_bw`. Both caps are captured when `start` is accepted.
- R4: If `req_rate` is zero, the search begins at the first entry. Otherwise the selector computes S = floor(req_rate/8)×10. The search then begins at entry k, where k is the number of entries after the first whose aggregate rate is at least S.
- R5: At each offer, `sink_cfg0` equals the bandwidth code. `sink_cfg1` carries the lane count in bits [4:0], and bit 7 is set when `sink_enh_frame` was high at start.
- R6: A result with `result_pass`=0 and `cfg_fail`=0 advances the search to the next fitting entry. A result with `result_pass`=1 ends the search with `link_ok`=1.
- R7: A result with `cfg_fail`=1 ends the search at once with `halted`=1, whatever `result_pass` says. No further entry is offered.
- R8: If no fitting entry remains, the search ends with `exhausted`=1. This includes the case where no entry fits at all.
- R9: A `start` pulse while `busy` is high has no effect on the search in progress.
- R10: `bw_code` and `lane_cnt` stay unchanged from the `cfg_strobe` cycle until the attempt result is taken.
- R11: After reset, `busy`, `cfg_strobe`, `link_ok`, `exhausted` and `halted` are all 0.
- R12: At most one of `link_ok`, `exhausted` and `halted` is high at any time. All three clear when a new search starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new search (accepted only while idle) |
| sink_max_lanes | input | 5 | Sink's maximum lane count |
| sink_max_bw | input | 8 | Sink's maximum bandwidth code |
| sink_enh_frame | input | 1 | Sink advertises enhanced framing |
| enc_max_lanes | input | 5 | Encoder lane limit |
| enc_max_bw | input | 8 | Encoder bandwidth-code limit |
| req_rate | input | 32 | Required payload rate in kB/s, 0 for none |
| result_valid | input | 1 | Attempt result is present this cycle |
| result_pass | input | 1 | Attempt trained successfully |
| cfg_fail | input | 1 | Configuration step failed outright |
| busy | output | 1 | Search in progress |
| cfg_strobe | output | 1 | One-cycle pulse: a new configuration is offered |
| bw_code | output | 8 | Offered bandwidth code |
| lane_cnt | output | 5 | Offered lane count |
| sink_cfg0 | output | 8 | First sink configuration byte |
| sink_cfg1 | output | 8 | Second sink configuration byte |
| link_ok | output | 1 | Search ended with a trained link |
| exhausted | output | 1 | Search ended with no candidate left |
| halted | output | 1 | Search stopped by a configuration failure |

## Verification
Two kinds of fault in the list index show at the ports on the very next offer. An index that is off by one, or a start point computed wrongly, gives a `bw_code`/`lane_cnt` pair that differs from the arithmetic walk. Either fault is caught at the first `cfg_strobe`, or one cycle later.

A wrong captured cap shows in two ways. It can let through an entry that should have been skipped. It can also skip a valid entry, which makes the offer sequence end early and raises `exhausted` after too few strobes.

A state machine that mishandles a result shows up within one cycle of `result_valid`. The outcome flag is wrong, or `busy` is wrong, or a further strobe appears after a halt.

// File: rtl/lfs_pkg.sv
package lfs_pkg;
  localparam int NUM_CFG   = 9;
  localparam int IDX_W     = $clog2(NUM_CFG + 1);
  localparam int BW_W      = 8;
  localparam int LANE_W    = 5;
  localparam int RATE_W    = 32;
  localparam int UNIT_KBPS = 27000;

  typedef struct packed {
    logic [BW_W-1:0]   bw;
    logic [LANE_W-1:0] lanes;
  } link_cfg_t;

  typedef enum logic [1:0] {ST_IDLE, ST_SEEK, ST_WAIT} fsm_t;

  // Candidate list, highest aggregate rate first.
  function automatic link_cfg_t cfg_entry(input logic [IDX_W-1:0] idx);
    link_cfg_t c;
    case (idx)
      IDX_W'(0): c = '{bw: 8'h14, lanes: 5'd4};
      IDX_W'(1): c = '{bw: 8'h0a, lanes: 5'd4};
      IDX_W'(2): c = '{bw: 8'h14, lanes: 5'd2};
      IDX_W'(3): c = '{bw: 8'h06, lanes: 5'd4};
      IDX_W'(4): c = '{bw: 8'h0a, lanes: 5'd2};
      IDX_W'(5): c = '{bw: 8'h14, lanes: 5'd1};
      IDX_W'(6): c = '{bw: 8'h06, lanes: 5'd2};
      IDX_W'(7): c = '{bw: 8'h0a, lanes: 5'd1};
      IDX_W'(8): c = '{bw: 8'h06, lanes: 5'd1};
      default:   c = '0;
    endcase
    return c;
  endfunction

  function automatic logic [RATE_W+1:0] cfg_rate(input link_cfg_t c);
    return (RATE_W+2)'(c.bw) * (RATE_W+2)'(UNIT_KBPS) * (RATE_W+2)'(c.lanes);
  endfunction

  // Payload rate scaled for 8b/10b overhead.
  function automatic logic [RATE_W+1:0] coded_rate(input logic [RATE_W-1:0] r);
    return (RATE_W+2)'(r >> 3) * (RATE_W+2)'(10);
  endfunction
endpackage

// File: rtl/lfs_cap_clamp.sv
module lfs_cap_clamp
  import lfs_pkg::*;
(
  input  logic [LANE_W-1:0] sink_lanes,
  input  logic [LANE_W-1:0] enc_lanes,
  input  logic [BW_W-1:0]   sink_bw,
  input  logic [BW_W-1:0]   enc_bw,
  output logic [LANE_W-1:0] cap_lanes,
  output logic [BW_W-1:0]   cap_bw
);
  assign cap_lanes = (sink_lanes < enc_lanes) ? sink_lanes : enc_lanes;
  assign cap_bw    = (sink_bw < enc_bw) ? sink_bw : enc_bw;
endmodule

// File: rtl/lfs_floor_finder.sv
module lfs_floor_finder
  import lfs_pkg::*;
(
  input  logic [RATE_W-1:0] req_rate,
  output logic [IDX_W-1:0]  start_idx
);
  logic [RATE_W+1:0]  floor_rate;
  logic [NUM_CFG-2:0] meets;

  assign floor_rate = coded_rate(req_rate);

  // The list is non-increasing in rate, so the count of successors meeting
  // the floor is the index of the cheapest entry that still meets it.
  for (genvar g = 1; g < NUM_CFG; g++) begin : g_cmp
    assign meets[g-1] = (req_rate != '0) &&
                        (cfg_rate(cfg_entry(IDX_W'(g))) >= floor_rate);
  end

  always_comb begin
    start_idx = '0;
    for (int i = 0; i < NUM_CFG - 1; i++)
      if (meets[i]) start_idx = start_idx + IDX_W'(1);
  end
endmodule

// File: rtl/lfs_entry_filter.sv
module lfs_entry_filter
  import lfs_pkg::*;
(
  input  logic [IDX_W-1:0]  idx,
  input  logic [LANE_W-1:0] cap_lanes,
  input  logic [BW_W-1:0]   cap_bw,
  output link_cfg_t         entry,
  output logic              at_end,
  output logic              fits
);
  assign entry  = cfg_entry(idx);
  assign at_end = (idx >= IDX_W'(NUM_CFG));
  assign fits   = !at_end && (entry.lanes <= cap_lanes) && (entry.bw <= cap_bw);
endmodule

// File: rtl/link_fallback_sel.sv
module link_fallback_sel
  import lfs_pkg::*;
#(
  parameter int ENH_BIT = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LANE_W-1:0] sink_max_lanes,
  input  logic [BW_W-1:0]   sink_max_bw,
  input  logic              sink_enh_frame,
  input  logic [LANE_W-1:0] enc_max_lanes,
  input  logic [BW_W-1:0]   enc_max_bw,
  input  logic [RATE_W-1:0] req_rate,
  input  logic              result_valid,
  input  logic              result_pass,
  input  logic              cfg_fail,
  output logic              busy,
  output logic              cfg_strobe,
  output logic [BW_W-1:0]   bw_code,
  output logic [LANE_W-1:0] lane_cnt,
  output logic [7:0]        sink_cfg0,
  output logic [7:0]        sink_cfg1,
  output logic              link_ok,
  output logic              exhausted,
  output logic              halted
);
  fsm_t              state;
  logic [IDX_W-1:0]  idx;
  logic [IDX_W-1:0]  start_idx;
  logic [LANE_W-1:0] clamp_lanes, cap_lanes_q;
  logic [BW_W-1:0]   clamp_bw, cap_bw_q;
  logic              enh_q;
  link_cfg_t         entry;
  logic              at_end, fits;
  logic [7:0]        cfg1_q;

  // Named internal events for the checker.
  logic accept_start, seek_hit, seek_end, waiting;
  logic res_halt, res_pass, res_retry;

  lfs_cap_clamp u_clamp (
    .sink_lanes(sink_max_lanes), .enc_lanes(enc_max_lanes),
    .sink_bw(sink_max_bw), .enc_bw(enc_max_bw),
    .cap_lanes(clamp_lanes), .cap_bw(clamp_bw)
  );

  lfs_floor_finder u_floor (
    .req_rate(req_rate), .start_idx(start_idx)
  );

  lfs_entry_filter u_filter (
    .idx(idx), .cap_lanes(cap_lanes_q), .cap_bw(cap_bw_q),
    .entry(entry), .at_end(at_end), .fits(fits)
  );

  assign waiting      = (state == ST_WAIT);
  assign accept_start = (state == ST_IDLE) && start;
  assign seek_end     = (state == ST_SEEK) && at_end;
  assign seek_hit     = (state == ST_SEEK) && fits;
  assign res_halt     = waiting && result_valid && cfg_fail;
  assign res_pass     = waiting && result_valid && !cfg_fail && result_pass;
  assign res_retry    = waiting && result_valid && !cfg_fail && !result_pass;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      idx         <= '0;
      cap_lanes_q <= '0;
      cap_bw_q    <= '0;
      enh_q       <= 1'b0;
      bw_code     <= '0;
      lane_cnt    <= '0;
      cfg1_q      <= '0;
      cfg_strobe  <= 1'b0;
      link_ok     <= 1'b0;
      exhausted   <= 1'b0;
      halted      <= 1'b0;
    end else begin
      cfg_strobe <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept_start) begin
          idx         <= start_idx;
          cap_lanes_q <= clamp_lanes;
          cap_bw_q    <= clamp_bw;
          enh_q       <= sink_enh_frame;
          link_ok     <= 1'b0;
          exhausted   <= 1'b0;
          halted      <= 1'b0;
          state       <= ST_SEEK;
        end
        ST_SEEK: begin
          if (seek_end) begin
            exhausted <= 1'b1;
            state     <= ST_IDLE;
          end else if (seek_hit) begin
            bw_code    <= entry.bw;
            lane_cnt   <= entry.lanes;
            cfg1_q     <= 8'(entry.lanes) | (8'(enh_q) << ENH_BIT);
            cfg_strobe <= 1'b1;
            state      <= ST_WAIT;
          end else begin
            idx <= idx + IDX_W'(1);
          end
        end
        ST_WAIT: begin
          if (res_halt) begin
            halted <= 1'b1;
            state  <= ST_IDLE;
          end else if (res_pass) begin
            link_ok <= 1'b1;
            state   <= ST_IDLE;
          end else if (res_retry) begin
            idx   <= idx + IDX_W'(1);
            state <= ST_SEEK;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state != ST_IDLE);
  assign sink_cfg0 = bw_code;
  assign sink_cfg1 = cfg1_q;
endmodule

// File: rtl/lfs_checker.sv
module lfs_checker
  import lfs_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [LANE_W-1:0] sink_max_lanes,
  input logic [LANE_W-1:0] enc_max_lanes,
  input logic [BW_W-1:0]   sink_max_bw,
  input logic [BW_W-1:0]   enc_max_bw,
  input logic              result_valid,
  input logic              result_pass,
  input logic              cfg_fail,
  input logic              busy,
  input logic              cfg_strobe,
  input logic [BW_W-1:0]   bw_code,
  input logic [LANE_W-1:0] lane_cnt,
  input logic [7:0]        sink_cfg0,
  input logic [7:0]        sink_cfg1,
  input logic              link_ok,
  input logic              exhausted,
  input logic              halted,
  input logic              waiting,
  input logic              enh_q,
  input logic [LANE_W-1:0] cap_lanes,
  input logic [BW_W-1:0]   cap_bw
);
  a_r2_within_caps: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_strobe |-> (lane_cnt <= cap_lanes) && (bw_code <= cap_bw));

  a_r3_caps_clamped: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (cap_lanes <= $past(sink_max_lanes)) && (cap_lanes <= $past(enc_max_lanes))
                 && (cap_bw <= $past(sink_max_bw)) && (cap_bw <= $past(enc_max_bw)));

  a_r5_cfg_bytes: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_strobe |-> (sink_cfg0 == bw_code) && (sink_cfg1[LANE_W-1:0] == lane_cnt)
                && ($countones(sink_cfg1[7:LANE_W]) == int'(enh_q)));

  a_r6_pass_ends: assert property (@(posedge clk) disable iff (!rst_n)
    waiting && result_valid && !cfg_fail && result_pass |=> link_ok && !busy);

  a_r7_fail_halts: assert property (@(posedge clk) disable iff (!rst_n)
    waiting && result_valid && cfg_fail |=> halted && !busy && !cfg_strobe);

  a_r8_exhausted_idle: assert property (@(posedge clk) disable iff (!rst_n)
    exhausted |-> !busy);

  a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    waiting && start && !result_valid |=> waiting);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    waiting && $past(waiting) |-> $stable(bw_code) && $stable(lane_cnt));

  a_r12_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({link_ok, exhausted, halted}));
endmodule

bind link_fallback_sel lfs_checker u_chk (
  .clk(clk), .rst_n(rst_n), .start(start),
  .sink_max_lanes(sink_max_lanes), .enc_max_lanes(enc_max_lanes),
  .sink_max_bw(sink_max_bw), .enc_max_bw(enc_max_bw),
  .result_valid(result_valid), .result_pass(result_pass), .cfg_fail(cfg_fail),
  .busy(busy), .cfg_strobe(cfg_strobe), .bw_code(bw_code), .lane_cnt(lane_cnt),
  .sink_cfg0(sink_cfg0), .sink_cfg1(sink_cfg1),
  .link_ok(link_ok), .exhausted(exhausted), .halted(halted),
  .waiting(waiting), .enh_q(enh_q), .cap_lanes(cap_lanes_q), .cap_bw(cap_bw_q)
);

// File: tb/tb_link_fallback_sel.sv
`timescale 1ns/1ps
module tb_link_fallback_sel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [4:0]  sink_max_lanes = '0, enc_max_lanes = '0;
  logic [7:0]  sink_max_bw = '0, enc_max_bw = '0;
  logic        sink_enh_frame = 1'b0;
  logic [31:0] req_rate = '0;
  logic        result_valid = 1'b0, result_pass = 1'b0, cfg_fail = 1'b0;
  logic        busy, cfg_strobe, link_ok, exhausted, halted;
  logic [7:0]  bw_code, sink_cfg0, sink_cfg1;
  logic [4:0]  lane_cnt;

  int n_checks = 0;
  int n_err = 0;
  bit finished = 0;

  int tbw[9] = '{20, 10, 20, 6, 10, 20, 6, 10, 6};
  int tln[9] = '{4, 4, 2, 4, 2, 1, 2, 1, 1};

  always #2.5 clk = ~clk;

  link_fallback_sel dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .sink_max_lanes(sink_max_lanes), .sink_max_bw(sink_max_bw),
    .sink_enh_frame(sink_enh_frame),
    .enc_max_lanes(enc_max_lanes), .enc_max_bw(enc_max_bw),
    .req_rate(req_rate), .result_valid(result_valid),
    .result_pass(result_pass), .cfg_fail(cfg_fail),
    .busy(busy), .cfg_strobe(cfg_strobe), .bw_code(bw_code), .lane_cnt(lane_cnt),
    .sink_cfg0(sink_cfg0), .sink_cfg1(sink_cfg1),
    .link_ok(link_ok), .exhausted(exhausted), .halted(halted)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // pass_at / err_at: attempt number that passes / fails outright, -1 for never.
  task automatic run_search(input int sl, input int sr, input int el, input int er,
                            input int enh, input int req, input int pass_at,
                            input int err_at, input bit poke);
    int exp_bw[9];
    int exp_ln[9];
    int n = 0;
    int cl = (sl < el) ? sl : el;
    int cr = (sr < er) ? sr : er;
    int st = 0;
    int k = 0;
    int guard = 0;
    int stop_k;
    int exp_flags;
    int held_bw, held_ln;
    if (req != 0) begin
      int s = (req / 8) * 10;
      while (st < 8 && tbw[st+1] * 27000 * tln[st+1] >= s) st++;
    end
    for (int i = st; i < 9; i++)
      if (tln[i] <= cl && tbw[i] <= cr) begin
        exp_bw[n] = tbw[i];
        exp_ln[n] = tln[i];
        n++;
      end
    stop_k = n;
    exp_flags = 3'b010;                       // {link_ok, exhausted, halted}
    if (err_at >= 0 && err_at < n && (pass_at < 0 || err_at <= pass_at)) begin
      stop_k = err_at + 1; exp_flags = 3'b001;
    end else if (pass_at >= 0 && pass_at < n) begin
      stop_k = pass_at + 1; exp_flags = 3'b100;
    end

    sink_max_lanes = 5'(sl); sink_max_bw = 8'(sr);
    enc_max_lanes = 5'(el); enc_max_bw = 8'(er);
    sink_enh_frame = enh[0]; req_rate = 32'(req);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk({link_ok, exhausted, halted} == 3'b000 && busy, "R12 flags cleared on start",
        int'({busy, link_ok, exhausted, halted}), 8);

    while (busy && guard < 200) begin
      guard++;
      if (cfg_strobe) begin
        if (k < n) begin
          chk(bw_code == 8'(exp_bw[k]) && lane_cnt == 5'(exp_ln[k]),
              (req != 0) ? "R1/R4 offer" : "R1/R2/R3 offer",
              int'(bw_code) * 100 + int'(lane_cnt), exp_bw[k] * 100 + exp_ln[k]);
          chk(sink_cfg0 == 8'(exp_bw[k]) &&
              sink_cfg1 == 8'(exp_ln[k] + (enh != 0 ? 128 : 0)),
              "R5 sink bytes", int'({sink_cfg0, sink_cfg1}),
              exp_bw[k] * 256 + exp_ln[k] + (enh != 0 ? 128 : 0));
        end else begin
          chk(1'b0, "R2/R8 extra offer", k, n);
        end
        held_bw = int'(bw_code); held_ln = int'(lane_cnt);
        start = poke;
        @(negedge clk) start = 1'b0;
        chk(int'(bw_code) == held_bw && int'(lane_cnt) == held_ln && busy,
            poke ? "R9 start while busy" : "R10 hold",
            int'(bw_code) * 100 + int'(lane_cnt), held_bw * 100 + held_ln);
        result_valid = 1'b1;
        result_pass = (k == pass_at);
        cfg_fail = (k == err_at);
        @(negedge clk);
        result_valid = 1'b0; result_pass = 1'b0; cfg_fail = 1'b0;
        k++;
      end else begin
        @(negedge clk);
      end
    end
    chk(k == stop_k, "R6/R7/R8 offer count", k, stop_k);
    chk(int'({link_ok, exhausted, halted}) == exp_flags && !busy,
        exp_flags == 4 ? "R6 link_ok" : (exp_flags == 1 ? "R7 halted" : "R8 exhausted"),
        int'({link_ok, exhausted, halted}), exp_flags);
  endtask

  initial begin
    int sls[4] = '{1, 2, 3, 4};
    int srs[3] = '{6, 10, 20};
    int els[3] = '{1, 2, 4};
    int ers[3] = '{6, 12, 20};
    int reqs[6] = '{0, 1000000, 500000, 432000, 200000, 100000};
    int it = 0;
    repeat (3) @(negedge clk);
    chk(!busy && !cfg_strobe && !link_ok && !exhausted && !halted, "R11 reset",
        int'({busy, cfg_strobe, link_ok, exhausted, halted}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !cfg_strobe, "R11 idle after reset", int'({busy, cfg_strobe}), 0);

    foreach (sls[a]) foreach (srs[b]) foreach (els[c]) foreach (ers[d]) foreach (reqs[e]) begin
      int pa = (it % 4 == 0) ? (it / 4) % 3 : -1;
      int ea = (it % 7 == 3) ? 1 : -1;
      run_search(sls[a], srs[b], els[c], ers[d], it % 2, reqs[e], pa, ea, it % 5 == 2);
      it++;
    end

    // Directed corners
    run_search(4, 20, 4, 20, 1, 0, -1, -1, 1'b0);   // full walk, R8
    run_search(4, 20, 4, 20, 0, 0, 0, -1, 1'b1);    // R6 first entry trains
    run_search(4, 20, 4, 20, 0, 0, 2, 2, 1'b0);     // R7 error wins over pass
    run_search(0, 20, 4, 20, 0, 0, -1, -1, 1'b0);   // R8 nothing fits
    run_search(4, 5, 4, 20, 0, 0, -1, -1, 1'b0);    // R8 rate cap below table
    run_search(4, 20, 4, 20, 1, 1728000, -1, -1, 1'b0); // R4 floor = 2160000

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end
endmodule